// File: doc/BRIEF.md
# CPU Idle and Stop Power-Mode Controller

This block governs the low-power states of a small 8-bit microcontroller core. Software asks for a sleep state by writing a two-bit power control register through a special-function-register write port. One bit asks for idle and the other asks for stop. The request is not acted on when it is written. It is acted on only when the core's instruction-retire strobe shows that the writing instruction has finished. From the current state the block drives clock enables for the CPU, for each peripheral lane, for the system oscillator and for the missing-clock detector.

Idle halts only the CPU clock. Peripherals and the oscillator keep running, and an enabled pending interrupt brings the core back. Stop halts everything except the missing-clock detector. Interrupts are ignored in stop, so only a reset request ends it. Any reset request, whether external, internal or from the watchdog, clears both register bits and issues a core reset pulse. A one-cycle wake pulse, with a cause flag, reports every wake-up. Register contents and memory are untouched by either sleep state, because no enable here touches storage.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The power control register sits at address `PCON_ADDR` (default 0x87). Bit 0 is the idle request and bit 1 is the stop request. A read at that address returns both bits with every other bit zero, and a read at any other address returns zero.
- R2: A register write by itself changes no enable. The request is acted on at the first clock edge where the retire strobe is high, either in the same cycle as the write or later, and the new state shows in the following cycle.
- R3: In idle, `cpu_clk_en_o` is low, while `osc_en_o`, `mcd_en_o` and every bit of `periph_clk_en_o` stay high.
- R4: An interrupt pending while in idle returns the block to run at the next edge. It clears the idle bit and raises `wake_o` with `wake_cause_o` = 0 (interrupt).
- R5: A nonzero `rst_src_i` while in idle or stop returns the block to run at the next edge, clears both bits and raises `core_rst_o` and `wake_o` with `wake_cause_o` = 1 (reset).
- R6: In stop, `cpu_clk_en_o`, `osc_en_o` and all peripheral enables are low and `mcd_en_o` stays high. Pending interrupts leave the block in stop.
- R7: When both bits are set at the retiring edge, stop is entered.
- R8: If an interrupt is pending in the cycle an idle request retires, idle is never entered. The idle bit is cleared and `wake_o` pulses with cause interrupt.
- R9: A nonzero `rst_src_i` while running clears both bits, cancels an unretired request and raises `core_rst_o` one cycle later, without `wake_o`.
- R10: Register writes are ignored while the block is in idle or stop.
- R11: `wake_o` is high for exactly one cycle per wake event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running control clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| sfr_we_i | input | 1 | Register write strobe |
| sfr_addr_i | input | AW | Register address for write and read |
| sfr_wdata_i | input | DW | Write data |
| sfr_rdata_o | output | DW | Read data, combinational from address |
| instr_retire_i | input | 1 | High in the last cycle of each instruction |
| irq_pend_i | input | 1 | An enabled interrupt is pending (level) |
| rst_src_i | input | NRST | Reset requests: external, internal, watchdog |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | NPERIPH | Peripheral clock enables |
| osc_en_o | output | 1 | System oscillator enable |
| mcd_en_o | output | 1 | Missing-clock detector enable |
| core_rst_o | output | 1 | Core reset pulse, one cycle after a reset request |
| wake_o | output | 1 | One-cycle wake event |
| wake_cause_o | output | 1 | 0 = interrupt, 1 = reset; valid with `wake_o` |

## Verification
The assertions assume that `irq_pend_i` is a level that a source keeps high until it is serviced, so sampling it once per cycle loses no wake-up. They also assume that reset requests are synchronous to `clk` and that a retire strobe following a register write belongs to the writing instruction. The random stimulus holds each input for a whole cycle and changes it only at the falling edge. It pulses reset requests rarely, so that long idle and stop stretches occur, and it mixes interrupts freely with retiring writes, so that the entry race of R8 comes up many times.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
   typedef enum logic [1:0] {
      PM_RUN  = 2'd0,
      PM_IDLE = 2'd1,
      PM_STOP = 2'd2
   } pm_state_e;

   typedef enum logic {
      WAKE_IRQ = 1'b0,
      WAKE_RST = 1'b1
   } wake_cause_e;

   typedef struct packed {
      logic stop;
      logic idle;
   } pm_req_t;
endpackage

// File: rtl/pwr_ctrl_reg.sv
module pwr_ctrl_reg
   import pwr_pkg::*;
#(
   parameter int DW        = 8,
   parameter int AW        = 8,
   parameter int PCON_ADDR = 'h87,
   parameter int IDLE_BIT  = 0,
   parameter int STOP_BIT  = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sfr_we_i,
   input  logic [AW-1:0] sfr_addr_i,
   input  logic [DW-1:0] sfr_wdata_i,
   output logic [DW-1:0] sfr_rdata_o,
   input  logic          run_i,
   input  logic          retire_i,
   input  logic          any_rst_i,
   input  logic          clr_idle_i,
   output logic          req_valid_o,
   output pm_req_t       req_o
);
   localparam logic [AW-1:0] ADDR_L = AW'(PCON_ADDR);

   pm_req_t bits_q, bits_d, wr_val;
   logic    armed_q, armed_d;
   logic    addr_hit, wr_hit;
   logic    unused_wdata;

   assign addr_hit     = (sfr_addr_i == ADDR_L);
   assign wr_hit       = sfr_we_i && addr_hit && run_i;
   assign wr_val.idle  = sfr_wdata_i[IDLE_BIT];
   assign wr_val.stop  = sfr_wdata_i[STOP_BIT];
   assign unused_wdata = ^sfr_wdata_i;

   // request seen at the retiring edge: a same-cycle write wins
   assign req_o       = wr_hit ? wr_val : bits_q;
   assign req_valid_o = run_i && retire_i && (armed_q || wr_hit);

   always_comb begin
      bits_d  = wr_hit ? wr_val : bits_q;
      armed_d = req_valid_o ? 1'b0 : (wr_hit ? (wr_val.idle | wr_val.stop) : armed_q);
      if (clr_idle_i) bits_d.idle = 1'b0;
      if (any_rst_i) begin
         bits_d  = '0;
         armed_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_q  <= '0;
         armed_q <= 1'b0;
      end else begin
         bits_q  <= bits_d;
         armed_q <= armed_d;
      end
   end

   always_comb begin
      sfr_rdata_o = '0;
      if (addr_hit) begin
         sfr_rdata_o[IDLE_BIT] = bits_q.idle;
         sfr_rdata_o[STOP_BIT] = bits_q.stop;
      end
   end

   // R5
   bits_clr_on_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_rst_i |=> (bits_q == '0 && !armed_q));

   // R10
   wr_ignored_halted_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sfr_we_i && !run_i && !any_rst_i && !clr_idle_i) |=> $stable(bits_q));
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
   import pwr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        any_rst_i,
   input  logic        irq_i,
   input  logic        req_valid_i,
   input  pm_req_t     req_i,
   output pm_state_e   state_o,
   output logic        clr_idle_o,
   output logic        wake_o,
   output wake_cause_e wake_cause_o,
   output logic        core_rst_o
);
   pm_state_e   state_q, state_d;
   logic        wake_q, wake_d, core_rst_q;
   wake_cause_e cause_q, cause_d;

   always_comb begin
      state_d    = state_q;
      wake_d     = 1'b0;
      cause_d    = cause_q;
      clr_idle_o = 1'b0;
      if (any_rst_i) begin
         state_d = PM_RUN;
         if (state_q != PM_RUN) begin
            wake_d  = 1'b1;
            cause_d = WAKE_RST;
         end
      end else begin
         unique case (state_q)
            PM_RUN: begin
               if (req_valid_i) begin
                  if (req_i.stop) begin
                     state_d = PM_STOP;
                  end else if (req_i.idle) begin
                     if (irq_i) begin
                        clr_idle_o = 1'b1;
                        wake_d     = 1'b1;
                        cause_d    = WAKE_IRQ;
                     end else begin
                        state_d = PM_IDLE;
                     end
                  end
               end
            end
            PM_IDLE: begin
               if (irq_i) begin
                  state_d    = PM_RUN;
                  clr_idle_o = 1'b1;
                  wake_d     = 1'b1;
                  cause_d    = WAKE_IRQ;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= PM_RUN;
         wake_q     <= 1'b0;
         cause_q    <= WAKE_IRQ;
         core_rst_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         wake_q     <= wake_d;
         cause_q    <= cause_d;
         core_rst_q <= any_rst_i;
      end
   end

   assign state_o      = state_q;
   assign wake_o       = wake_q;
   assign wake_cause_o = cause_q;
   assign core_rst_o   = core_rst_q;

   // R2
   entry_on_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PM_RUN && !req_valid_i) |=> (state_q == PM_RUN));

   // R6
   stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PM_STOP && !any_rst_i) |=> (state_q == PM_STOP && !wake_o));

   // R4
   irq_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PM_IDLE && irq_i && !any_rst_i) |=>
         (state_q == PM_RUN && wake_o && wake_cause_o == WAKE_IRQ));

   // R5
   rst_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_rst_i && state_q != PM_RUN) |=>
         (state_q == PM_RUN && wake_o && wake_cause_o == WAKE_RST && core_rst_o));

   // R7
   stop_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PM_RUN && req_valid_i && req_i.stop && !any_rst_i) |=> (state_q == PM_STOP));

   // R8
   race_no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PM_RUN && req_valid_i && !req_i.stop && req_i.idle && irq_i && !any_rst_i)
         |=> (state_q == PM_RUN && wake_o));
endmodule

// File: rtl/pwr_clk_en.sv
module pwr_clk_en
   import pwr_pkg::*;
#(
   parameter int NPERIPH = 4,
   parameter bit REG_OUT = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  pm_state_e          state_i,
   output logic               cpu_clk_en_o,
   output logic [NPERIPH-1:0] periph_clk_en_o,
   output logic               osc_en_o,
   output logic               mcd_en_o
);
   logic cpu_d, run_clk_d;
   logic mcd_q;

   assign cpu_d     = (state_i == PM_RUN);
   assign run_clk_d = (state_i != PM_STOP);

   // detector enable comes up with the block and never drops afterwards
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mcd_q <= 1'b0;
      else        mcd_q <= 1'b1;
   end
   assign mcd_en_o = mcd_q;

   if (REG_OUT) begin : g_reg
      logic cpu_q, osc_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cpu_q <= 1'b1;
            osc_q <= 1'b1;
         end else begin
            cpu_q <= cpu_d;
            osc_q <= run_clk_d;
         end
      end
      assign cpu_clk_en_o = cpu_q;
      assign osc_en_o     = osc_q;
      for (genvar i = 0; i < NPERIPH; i++) begin : g_lane
         logic en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) en_q <= 1'b1;
            else        en_q <= run_clk_d;
         end
         assign periph_clk_en_o[i] = en_q;
      end
   end else begin : g_comb
      assign cpu_clk_en_o = cpu_d;
      assign osc_en_o     = run_clk_d;
      for (genvar i = 0; i < NPERIPH; i++) begin : g_lane
         assign periph_clk_en_o[i] = run_clk_d;
      end
   end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
   import pwr_pkg::*;
#(
   parameter int DW        = 8,
   parameter int AW        = 8,
   parameter int PCON_ADDR = 'h87,
   parameter int IDLE_BIT  = 0,
   parameter int STOP_BIT  = 1,
   parameter int NRST      = 3,
   parameter int NPERIPH   = 4,
   parameter bit REG_OUT   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sfr_we_i,
   input  logic [AW-1:0]      sfr_addr_i,
   input  logic [DW-1:0]      sfr_wdata_i,
   output logic [DW-1:0]      sfr_rdata_o,
   input  logic               instr_retire_i,
   input  logic               irq_pend_i,
   input  logic [NRST-1:0]    rst_src_i,
   output logic               cpu_clk_en_o,
   output logic [NPERIPH-1:0] periph_clk_en_o,
   output logic               osc_en_o,
   output logic               mcd_en_o,
   output logic               core_rst_o,
   output logic               wake_o,
   output logic               wake_cause_o
);
   if (DW < 2) begin : g_bad_dw
      $error("DW must hold both mode bits");
   end
   if (IDLE_BIT < 0 || IDLE_BIT >= DW || STOP_BIT < 0 || STOP_BIT >= DW) begin : g_bad_pos
      $error("mode bit position outside the data word");
   end
   if (IDLE_BIT == STOP_BIT) begin : g_bad_overlap
      $error("idle and stop bits must differ");
   end
   if (AW < 1 || AW > 30 || PCON_ADDR < 0 || PCON_ADDR >= (1 << AW)) begin : g_bad_addr
      $error("register address does not fit AW");
   end
   if (NRST < 1 || NPERIPH < 1) begin : g_bad_cnt
      $error("NRST and NPERIPH must be at least one");
   end

   pm_state_e   state;
   pm_req_t     req;
   logic        req_valid, clr_idle, any_rst;
   wake_cause_e cause;

   assign any_rst = |rst_src_i;

   pwr_ctrl_reg #(
      .DW(DW), .AW(AW), .PCON_ADDR(PCON_ADDR),
      .IDLE_BIT(IDLE_BIT), .STOP_BIT(STOP_BIT)
   ) u_reg (
      .clk         (clk),
      .rst_n       (rst_n),
      .sfr_we_i    (sfr_we_i),
      .sfr_addr_i  (sfr_addr_i),
      .sfr_wdata_i (sfr_wdata_i),
      .sfr_rdata_o (sfr_rdata_o),
      .run_i       (state == PM_RUN),
      .retire_i    (instr_retire_i),
      .any_rst_i   (any_rst),
      .clr_idle_i  (clr_idle),
      .req_valid_o (req_valid),
      .req_o       (req)
   );

   pwr_mode_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .any_rst_i    (any_rst),
      .irq_i        (irq_pend_i),
      .req_valid_i  (req_valid),
      .req_i        (req),
      .state_o      (state),
      .clr_idle_o   (clr_idle),
      .wake_o       (wake_o),
      .wake_cause_o (cause),
      .core_rst_o   (core_rst_o)
   );

   assign wake_cause_o = cause;

   pwr_clk_en #(.NPERIPH(NPERIPH), .REG_OUT(REG_OUT)) u_clk (
      .clk             (clk),
      .rst_n           (rst_n),
      .state_i         (state),
      .cpu_clk_en_o    (cpu_clk_en_o),
      .periph_clk_en_o (periph_clk_en_o),
      .osc_en_o        (osc_en_o),
      .mcd_en_o        (mcd_en_o)
   );

   // R9
   run_rst_no_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (any_rst && cpu_clk_en_o && !REG_OUT) |=> (core_rst_o && !wake_o));
endmodule

// File: tb/tb_pwr_mode_ctrl.sv
module tb_pwr_mode_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] ADDR = 8'h87;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sfr_we = 1'b0;
   logic [7:0] sfr_addr = '0;
   logic [7:0] sfr_wdata = '0;
   logic [7:0] sfr_rdata;
   logic       retire = 1'b0;
   logic       irq = 1'b0;
   logic [2:0] rst_src = '0;
   logic       cpu_en, osc_en, mcd_en, core_rst, wake, cause;
   logic [3:0] periph_en;

   int n_chk = 0;
   int n_bad = 0;

   // reference model: 0 run, 1 idle, 2 stop
   int       m_st = 0;
   bit [1:0] m_bits = '0;
   bit       m_armed = 1'b0;
   bit       m_wake = 1'b0;
   bit       m_cause = 1'b0;
   bit       m_crst = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pwr_mode_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .sfr_we_i(sfr_we), .sfr_addr_i(sfr_addr), .sfr_wdata_i(sfr_wdata),
      .sfr_rdata_o(sfr_rdata), .instr_retire_i(retire), .irq_pend_i(irq),
      .rst_src_i(rst_src), .cpu_clk_en_o(cpu_en), .periph_clk_en_o(periph_en),
      .osc_en_o(osc_en), .mcd_en_o(mcd_en), .core_rst_o(core_rst),
      .wake_o(wake), .wake_cause_o(cause)
   );

   task automatic cmp(input string tag, input string what, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
      end
   endtask

   function automatic bit [7:0] exp_rdata(input bit [7:0] a, input bit [1:0] b);
      return (a == ADDR) ? {6'b0, b} : 8'h00;
   endfunction

   task automatic check_all(input string tag);
      cmp(tag, "cpu_clk_en R2/R3", cpu_en, m_st == 0);
      cmp(tag, "periph_clk_en R3/R6", periph_en, (m_st != 2) ? 4'hF : 4'h0);
      cmp(tag, "osc_en R3/R6", osc_en, m_st != 2);
      cmp(tag, "mcd_en R6", mcd_en, 1);
      cmp(tag, "core_rst R5/R9", core_rst, m_crst);
      cmp(tag, "wake R4/R5/R11", wake, m_wake);
      if (m_wake) cmp(tag, "wake_cause R4/R5/R8", cause, m_cause);
      cmp(tag, "rdata R1/R10", sfr_rdata, exp_rdata(sfr_addr, m_bits));
   endtask

   function automatic void model_edge(input bit we, input bit [7:0] a, input bit [7:0] wd,
                                      input bit ret, input bit ir, input bit [2:0] rs);
      bit       hit;
      bit [1:0] eff;
      m_wake = 1'b0;
      m_crst = (rs != 0);
      if (rs != 0) begin
         if (m_st != 0) begin
            m_wake  = 1'b1;
            m_cause = 1'b1;
         end
         m_st = 0; m_bits = '0; m_armed = 1'b0;
         return;
      end
      hit = we && (a == ADDR) && (m_st == 0);
      eff = hit ? wd[1:0] : m_bits;
      if (hit) begin
         m_bits  = wd[1:0];
         m_armed = |wd[1:0];
      end
      if (m_st == 0 && ret && (m_armed || hit)) begin
         m_armed = 1'b0;
         if (eff[1]) m_st = 2;
         else if (eff[0]) begin
            if (ir) begin
               m_bits[0] = 1'b0; m_wake = 1'b1; m_cause = 1'b0;
            end else m_st = 1;
         end
      end else if (m_st == 1 && ir) begin
         m_st = 0; m_bits[0] = 1'b0; m_wake = 1'b1; m_cause = 1'b0;
      end
   endfunction

   task automatic step(input string tag, input bit we, input bit [7:0] a, input bit [7:0] wd,
                       input bit ret, input bit ir, input bit [2:0] rs);
      @(negedge clk);
      sfr_we = we; sfr_addr = a; sfr_wdata = wd; retire = ret; irq = ir; rst_src = rs;
      #1;
      check_all(tag);
      model_edge(we, a, wd, ret, ir, rs);
   endtask

   task automatic nop(input string tag, input bit ir);
      step(tag, 1'b0, ADDR, 8'h00, 1'b0, ir, 3'b000);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      repeat (2) @(posedge clk);

      // R1 reset state and readback
      nop("R1 reset", 1'b0);
      step("R1 other addr", 1'b0, 8'h10, 8'h00, 1'b0, 1'b0, 3'b000);
      // R2 write without retire, then retire enters idle; R3 idle enables
      step("R2 write", 1'b1, ADDR, 8'h01, 1'b0, 1'b0, 3'b000);
      nop("R2 no retire", 1'b0);
      step("R2 retire", 1'b0, ADDR, 8'h00, 1'b1, 1'b0, 3'b000);
      nop("R3 idle", 1'b0);
      // R10 write while idle is ignored
      step("R10 write idle", 1'b1, ADDR, 8'h02, 1'b1, 1'b0, 3'b000);
      nop("R10 readback", 1'b0);
      // R4 interrupt wakes idle, R11 single pulse
      nop("R4 irq", 1'b1);
      nop("R11 after wake", 1'b0);
      nop("R11 pulse end", 1'b0);
      // R7 both bits with same-cycle retire give stop; R6 irq ignored
      step("R7 both", 1'b1, ADDR, 8'h03, 1'b1, 1'b0, 3'b000);
      nop("R6 stop", 1'b1);
      nop("R6 stop irq", 1'b1);
      // R5 watchdog reset leaves stop
      step("R5 rst stop", 1'b0, ADDR, 8'h00, 1'b0, 1'b1, 3'b100);
      nop("R5 after", 1'b0);
      // R8 interrupt in the retiring cycle
      step("R8 race", 1'b1, ADDR, 8'h01, 1'b1, 1'b1, 3'b000);
      nop("R8 after", 1'b0);
      nop("R8 settle", 1'b0);
      // R5 external reset leaves idle
      step("R5 idle enter", 1'b1, ADDR, 8'h01, 1'b1, 1'b0, 3'b000);
      step("R5 rst idle", 1'b0, ADDR, 8'h00, 1'b0, 1'b0, 3'b001);
      nop("R5 idle after", 1'b0);
      // R1 upper bits not stored
      step("R1 upper", 1'b1, ADDR, 8'hFC, 1'b1, 1'b0, 3'b000);
      nop("R1 upper rd", 1'b0);
      // R9 reset in run cancels an unretired request
      step("R9 write", 1'b1, ADDR, 8'h01, 1'b0, 1'b0, 3'b000);
      step("R9 rst run", 1'b0, ADDR, 8'h00, 1'b0, 1'b0, 3'b010);
      step("R9 retire", 1'b0, ADDR, 8'h00, 1'b1, 1'b0, 3'b000);
      nop("R9 still run", 1'b0);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         int unsigned r;
         bit [7:0] a;
         bit [2:0] rs;
         r  = $urandom();
         a  = (r[3:2] == 2'b00) ? 8'($urandom()) : ADDR;
         rs = ((r[15:8] % 50) == 0) ? 3'($urandom_range(1, 7)) : 3'b000;
         step("rand", (r[6:4] == 3'd0) || (r[6:4] == 3'd1), a, 8'($urandom()),
              (r[20:18] < 3), (r[25:22] < 3), rs);
      end
      nop("final", 1'b0);

      summary();
      $finish;
   end
endmodule